// File: doc/BRIEF.md
# Triple Frame Buffer Index Controller

This block assigns three frame buffers in external memory to a video write channel and a video read channel. The write side fills one buffer at a time. Each time it finishes a frame, it signals this with a single-cycle completion pulse, and the controller moves it on to the next buffer in the ring.

The read side is always given the buffer that lies one step behind the buffer now being written. That buffer holds the most recently completed frame. The read assignment is taken only when the reader starts a new frame, so a frame that is already being fetched is never switched part way through.

For each channel the block drives two outputs: a buffer index, and the base address that goes with it. The address is a fixed region base plus the index times the frame size. Both the base and the frame size are design parameters. The two DMA engines consume these outputs.

Top module: `tribuf_ctrl`

## Requirements
- R1: In the cycle after synchronous reset is released, `wr_idx` is 0 and `rd_idx` is 2. Indices are plain 2-bit binary numbers.
- R2: Each cycle with `wr_done` high, `wr_idx` advances one step along the ring 0→1→2→0. The new value is visible in the following cycle.
- R3: When `wr_done` is low, `wr_idx` keeps its value.
- R4: After a cycle with `rd_start` high, `rd_idx` equals the buffer one step behind the updated `wr_idx`, which is (`wr_idx` + 2) mod 3.
- R5: When `rd_start` is low, `rd_idx` keeps its value, including across any number of `wr_done` pulses.
- R6: When `wr_done` and `rd_start` are high in the same cycle, `rd_idx` takes the index of the buffer whose write just completed, which is the value `wr_idx` had in that cycle.
- R7: `wr_base` always equals BASE_ADDR + `wr_idx` × FRAME_BYTES, computed modulo 2^ADDR_W.
- R8: `rd_base` always equals BASE_ADDR + `rd_idx` × FRAME_BYTES, computed modulo 2^ADDR_W.
- R9: Neither index ever takes the value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_done | input | 1 | One-cycle pulse: the write channel finished a frame |
| rd_start | input | 1 | One-cycle pulse: the read channel begins a frame |
| wr_idx | output | 2 | Buffer the write channel fills |
| wr_base | output | ADDR_W (32) | Base address of the write buffer |
| rd_idx | output | 2 | Buffer the read channel fetches |
| rd_base | output | ADDR_W (32) | Base address of the read buffer |

## Verification
The bench targets three corner cases.

The first is completion and read start arriving in the same cycle. A design that samples the stale write index there would hand the reader a frame one generation older than the one just finished.

The second is several completions with no read start in between. A design that tracks the writer continuously, instead of latching at the read boundary, would move `rd_idx` mid-frame.

The third is the wrap from buffer 2 back to 0, together with the reset pair 0/2. A ring counter that miscounts would reach index 3 or an address outside the three regions.

// File: rtl/tribuf_pkg.sv
package tribuf_pkg;

    localparam int NUM_BUFS = 3;
    localparam int IDX_W    = 2;

    typedef logic [IDX_W-1:0] buf_idx_t;

    // Frame events seen by the controller in one cycle
    typedef struct packed {
        logic wr_done;
        logic rd_start;
    } frame_evt_t;

    localparam buf_idx_t WR_RESET_IDX = buf_idx_t'(0);
    localparam buf_idx_t RD_RESET_IDX = buf_idx_t'(NUM_BUFS - 1);

    function automatic buf_idx_t idx_next(input buf_idx_t i);
        return (i == buf_idx_t'(NUM_BUFS - 1)) ? buf_idx_t'(0) : buf_idx_t'(i + 1'b1);
    endfunction

    function automatic buf_idx_t idx_prev(input buf_idx_t i);
        return (i == buf_idx_t'(0)) ? buf_idx_t'(NUM_BUFS - 1) : buf_idx_t'(i - 1'b1);
    endfunction

endpackage

// File: rtl/tribuf_wr_ring.sv
module tribuf_wr_ring
    import tribuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_evt_t evt,
    output buf_idx_t   wr_idx
);

    buf_idx_t cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= WR_RESET_IDX;
        end else if (evt.wr_done) begin
            cur_q <= idx_next(cur_q);
        end
    end

    assign wr_idx = cur_q;

endmodule

// File: rtl/tribuf_rd_latch.sv
module tribuf_rd_latch
    import tribuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_evt_t evt,
    input  buf_idx_t   wr_idx,
    output buf_idx_t   rd_idx
);

    buf_idx_t target;
    buf_idx_t rd_q;

    // On a completion in this cycle, the buffer just finished is wr_idx itself.
    always_comb begin
        if (evt.wr_done) begin
            target = wr_idx;
        end else begin
            target = idx_prev(wr_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= RD_RESET_IDX;
        end else if (evt.rd_start) begin
            rd_q <= target;
        end
    end

    assign rd_idx = rd_q;

endmodule

// File: rtl/tribuf_addr_map.sv
module tribuf_addr_map
    import tribuf_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] FRAME_BYTES = 32'h0004_B000
)(
    input  buf_idx_t          idx,
    output logic [ADDR_W-1:0] base
);

    logic [ADDR_W-1:0] region [NUM_BUFS];

    for (genvar g = 0; g < NUM_BUFS; g++) begin : g_region
        assign region[g] = BASE_ADDR + ADDR_W'(g) * FRAME_BYTES;
    end

    always_comb begin
        case (idx)
            buf_idx_t'(1): base = region[1];
            buf_idx_t'(2): base = region[2];
            default:       base = region[0];
        endcase
    end

endmodule

// File: rtl/tribuf_ctrl.sv
module tribuf_ctrl
    import tribuf_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] FRAME_BYTES = 32'h0004_B000
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_done,
    input  logic              rd_start,
    output logic [1:0]        wr_idx,
    output logic [ADDR_W-1:0] wr_base,
    output logic [1:0]        rd_idx,
    output logic [ADDR_W-1:0] rd_base
);

    frame_evt_t evt;
    buf_idx_t   w_idx;
    buf_idx_t   r_idx;

    assign evt.wr_done  = wr_done;
    assign evt.rd_start = rd_start;

    tribuf_wr_ring u_wr (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .wr_idx (w_idx)
    );

    tribuf_rd_latch u_rd (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .wr_idx (w_idx),
        .rd_idx (r_idx)
    );

    tribuf_addr_map #(
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE_ADDR),
        .FRAME_BYTES (FRAME_BYTES)
    ) u_wmap (
        .idx  (w_idx),
        .base (wr_base)
    );

    tribuf_addr_map #(
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE_ADDR),
        .FRAME_BYTES (FRAME_BYTES)
    ) u_rmap (
        .idx  (r_idx),
        .base (rd_base)
    );

    assign wr_idx = w_idx;
    assign rd_idx = r_idx;

endmodule

// File: rtl/tribuf_ctrl_chk.sv
module tribuf_ctrl_chk
    import tribuf_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 32'h1000_0000,
    parameter logic [ADDR_W-1:0] FRAME_BYTES = 32'h0004_B000
)(
    input logic              clk,
    input logic              rst,
    input logic              wr_done,
    input logic              rd_start,
    input logic [1:0]        wr_idx,
    input logic [ADDR_W-1:0] wr_base,
    input logic [1:0]        rd_idx,
    input logic [ADDR_W-1:0] rd_base
);

    // R1
    reset_pair_chk: assert property (@(posedge clk) rst |=> (wr_idx == 2'd0 && rd_idx == 2'd2));

    // R2
    wr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        wr_done |=> wr_idx == idx_next($past(wr_idx)));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_done |=> $stable(wr_idx));

    // R4
    rd_behind_chk: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> rd_idx == idx_prev(wr_idx));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_start |=> $stable(rd_idx));

    // R6
    rd_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_done && rd_start) |=> rd_idx == $past(wr_idx));

    // R7
    wr_region_chk: assert property (@(posedge clk) disable iff (rst)
        wr_base == BASE_ADDR + ADDR_W'(wr_idx) * FRAME_BYTES);

    // R8
    rd_region_chk: assert property (@(posedge clk) disable iff (rst)
        rd_base == BASE_ADDR + ADDR_W'(rd_idx) * FRAME_BYTES);

    // R9
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_idx != 2'd3 && rd_idx != 2'd3);

endmodule

bind tribuf_ctrl tribuf_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .BASE_ADDR   (BASE_ADDR),
    .FRAME_BYTES (FRAME_BYTES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_done  (wr_done),
    .rd_start (rd_start),
    .wr_idx   (wr_idx),
    .wr_base  (wr_base),
    .rd_idx   (rd_idx),
    .rd_base  (rd_base)
);

// File: tb/sim_tribuf_ctrl.sv
`timescale 1ns/1ps
module sim_tribuf_ctrl;

    localparam int          AW    = 32;
    localparam logic [31:0] BASE  = 32'h1000_0000;
    localparam logic [31:0] FRAME = 32'h0004_B000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_done = 1'b0;
    logic          rd_start = 1'b0;
    logic [1:0]    wr_idx;
    logic [1:0]    rd_idx;
    logic [AW-1:0] wr_base;
    logic [AW-1:0] rd_base;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int m_wr   = 0;
    int m_rd   = 2;

    always #10 clk = ~clk;

    tribuf_ctrl #(.ADDR_W(AW), .BASE_ADDR(BASE), .FRAME_BYTES(FRAME)) u0 (
        .clk      (clk),
        .rst      (rst),
        .wr_done  (wr_done),
        .rd_start (rd_start),
        .wr_idx   (wr_idx),
        .wr_base  (wr_base),
        .rd_idx   (rd_idx),
        .rd_base  (rd_base)
    );

    function automatic logic [31:0] region(input int i);
        return BASE + 32'(i) * FRAME;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic compare(input logic wd, input logic rs);
        check(wd ? "R2 write advance" : "R3 write hold", 32'(wr_idx), 32'(m_wr));
        if (wd && rs)  check("R6 same-cycle read", 32'(rd_idx), 32'(m_rd));
        else if (rs)   check("R4 read behind write", 32'(rd_idx), 32'(m_rd));
        else           check("R5 read hold", 32'(rd_idx), 32'(m_rd));
        check("R7 write base", wr_base, region(m_wr));
        check("R8 read base", rd_base, region(m_rd));
        check("R9 index range", 32'((wr_idx == 2'd3) || (rd_idx == 2'd3)), 32'd0);
    endtask

    // Called at a falling edge; drives, clocks, updates the model, compares.
    task automatic step(input logic wd, input logic rs);
        int nw;
        wr_done  = wd;
        rd_start = rs;
        @(posedge clk);
        nw = wd ? (m_wr + 1) % 3 : m_wr;
        if (rs) m_rd = (nw + 2) % 3;
        m_wr = nw;
        @(negedge clk);
        compare(wd, rs);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R1 reset pair and addresses
        check("R1 reset write idx", 32'(wr_idx), 32'd0);
        check("R1 reset read idx", 32'(rd_idx), 32'd2);
        check("R1 reset write base", wr_base, region(0));
        check("R1 reset read base", rd_base, region(2));

        // R3 idle holds
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
        // R2 full wrap 0->1->2->0->1 with reader untouched (R5)
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        // R4 read start alone
        step(1'b0, 1'b1);
        // R5 several completions with no read start
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        // R6 simultaneous completion and read start, across each buffer
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1);
        // R4 back-to-back read starts
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);

        // Mixed pattern
        for (int i = 0; i < 2000; i++) begin
            logic wd;
            logic rs;
            wd = ($urandom % 3) == 0;
            rs = ($urandom % 4) == 0;
            step(wd, rs);
        end

        // Reset in mid-stream returns to the R1 pair
        rst = 1'b1;
        wr_done = 1'b1;
        rd_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wr_done = 1'b0;
        rd_start = 1'b0;
        m_wr = 0;
        m_rd = 2;
        check("R1 re-reset write idx", 32'(wr_idx), 32'd0);
        check("R1 re-reset read idx", 32'(rd_idx), 32'd2);
        step(1'b1, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule